// File: doc/BRIEF.md
# One-hot Mealy controller with working-area flag

This block is a four-state Mealy controller. It has three control inputs and three outputs. The state sits in a four-bit one-hot register. Both the next state and the outputs come from a sum of products built from a fixed transition table. Each product looks only at the register bit of its own source state and at the inputs. The other state bits are left free, so the logic has a defined result for all sixteen register codes, including the ones that are not one-hot. When several bits are set, each set bit contributes its own row, and the results are merged by OR.

A combinational flag marks full states (inputs together with register contents) that fall outside the specified working area. A full state is inside the working area only when the register is exactly one-hot and the inputs match one of the cubes listed for that state.

A direct load port can write any code into the register. It is used to put the machine into a known state, including states outside the working area. A host uses the outputs and the flag in the same cycle as the inputs; the register advances on every clock edge.

Top module: `ohm_ctrl`

## Requirements
- R1: While `rst_n` is low, the register holds 4'b0001 (state 1). Right after release, `out_of_area` is 0.
- R2: Encoding used by R2 to R5: `x_i[k-1]` is input xk, `y_o[k-1]` is output yk, and `state_o[k-1]` is the bit of state k. In state 1: if x1=0 or x2=0, the machine stays in state 1 with y1y2y3=001. If x1=x2=1, it moves to state 2 with 101.
- R3: In state 2: if x3=0, it stays with y1y2y3=011. If x3=1, it moves to state 3 with 111.
- R4: In state 3: if x1=1 and x2=0, it stays with 010. If x1=0, it moves to state 4 with 110. If x1=x2=1, it moves to state 4 with 011.
- R5: In state 4: if x3=0, it stays with 011. If x3=1, it moves to state 1 with 111.
- R6: When more than one register bit is set, the next code is the OR of the single-state next codes for every set bit under the current inputs. The outputs are the OR of those rows' outputs.
- R7: With register 4'b0000, the outputs are 000 and the register stays 4'b0000 unless a load occurs.
- R8: `out_of_area` is 1 exactly when the register is not one-hot, or when the inputs match no cube of the current state. The table covers every input for each state, so every one-hot code gives 0.
- R9: When `ld_en` is high at a clock edge, the register takes `ld_val`. The load wins over the table transition.
- R10: From any one-hot code without a load, the next code is again one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the host |
| x_i | input | 3 | Control inputs, bit k-1 is xk |
| ld_en | input | 1 | Load the register with `ld_val` at the next edge |
| ld_val | input | 4 | Code to load, bit k-1 is state k |
| y_o | output | 3 | Mealy outputs, bit k-1 is yk |
| state_o | output | 4 | Current register contents |
| out_of_area | output | 1 | Current full state is outside the working area |

## Verification
The properties assume that `ld_en` and `ld_val` are driven to known values in every clocked cycle. They also assume the inputs change only between edges, so the value sampled at an edge is the one the logic used. The stimulus drives every input on the falling edge and holds it across the next rising edge. It walks the table from reset using only the control inputs. It then loads each of the sixteen codes and applies all eight input patterns to each one. This reaches the non-one-hot and all-zero codes through the load port rather than by forcing internal nodes.

// File: rtl/ohm_pkg.sv
package ohm_pkg;
  localparam int NUM_STATES = 4;
  localparam int NUM_IN     = 3;
  localparam int NUM_OUT    = 3;
  localparam int NUM_RULES  = 10;
  localparam int ST_IDX_W   = $clog2(NUM_STATES);

  localparam logic [NUM_STATES-1:0] RESET_CODE = NUM_STATES'(1);

  // One product of the sum: a source state bit, an input cube (care/value),
  // the destination state and the output vector raised by the product.
  typedef struct packed {
    logic [ST_IDX_W-1:0] src;
    logic [NUM_IN-1:0]   care;
    logic [NUM_IN-1:0]   val;
    logic [ST_IDX_W-1:0] dst;
    logic [NUM_OUT-1:0]  out;
  } rule_t;

  // Input bit k-1 = xk, output bit k-1 = yk.
  localparam rule_t RULES [NUM_RULES] = '{
    '{src: 2'd0, care: 3'b001, val: 3'b000, dst: 2'd0, out: 3'b100},
    '{src: 2'd0, care: 3'b010, val: 3'b000, dst: 2'd0, out: 3'b100},
    '{src: 2'd0, care: 3'b011, val: 3'b011, dst: 2'd1, out: 3'b101},
    '{src: 2'd1, care: 3'b100, val: 3'b000, dst: 2'd1, out: 3'b110},
    '{src: 2'd1, care: 3'b100, val: 3'b100, dst: 2'd2, out: 3'b111},
    '{src: 2'd2, care: 3'b011, val: 3'b001, dst: 2'd2, out: 3'b010},
    '{src: 2'd2, care: 3'b001, val: 3'b000, dst: 2'd3, out: 3'b011},
    '{src: 2'd2, care: 3'b011, val: 3'b011, dst: 2'd3, out: 3'b110},
    '{src: 2'd3, care: 3'b100, val: 3'b000, dst: 2'd3, out: 3'b110},
    '{src: 2'd3, care: 3'b100, val: 3'b100, dst: 2'd0, out: 3'b111}
  };
endpackage

// File: rtl/ohm_product_plane.sv
module ohm_product_plane
  import ohm_pkg::*;
(
  input  logic [NUM_IN-1:0]     x_i,
  input  logic [NUM_STATES-1:0] z_i,
  output logic [NUM_RULES-1:0]  hit_o
);
  // Each product tests only its own source state bit; other bits are free.
  for (genvar r = 0; r < NUM_RULES; r++) begin : g_prod
    assign hit_o[r] = z_i[RULES[r].src] &
                      ((x_i & RULES[r].care) == RULES[r].val);
  end
endmodule

// File: rtl/ohm_or_plane.sv
module ohm_or_plane
  import ohm_pkg::*;
(
  input  logic [NUM_RULES-1:0]  hit_i,
  output logic [NUM_STATES-1:0] nxt_o,
  output logic [NUM_OUT-1:0]    y_o
);
  always_comb begin
    nxt_o = '0;
    y_o   = '0;
    for (int r = 0; r < NUM_RULES; r++) begin
      if (hit_i[r]) begin
        nxt_o[RULES[r].dst] = 1'b1;
        y_o                 = y_o | RULES[r].out;
      end
    end
  end
endmodule

// File: rtl/ohm_area_check.sv
module ohm_area_check
  import ohm_pkg::*;
(
  input  logic [NUM_STATES-1:0] z_i,
  input  logic [NUM_RULES-1:0]  hit_i,
  output logic                  outside_o
);
  logic [NUM_STATES-1:0] covered;
  logic                  single;

  always_comb begin
    covered = '0;
    for (int r = 0; r < NUM_RULES; r++) begin
      if (hit_i[r]) covered[RULES[r].src] = 1'b1;
    end
  end

  // Exactly one bit set: non-zero and clearing the lowest set bit leaves zero.
  assign single    = (z_i != '0) && ((z_i & (z_i - 1'b1)) == '0);
  assign outside_o = !(single && ((covered & z_i) != '0));
endmodule

// File: rtl/ohm_ctrl.sv
module ohm_ctrl
  import ohm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IN-1:0]     x_i,
  input  logic                  ld_en,
  input  logic [NUM_STATES-1:0] ld_val,
  output logic [NUM_OUT-1:0]    y_o,
  output logic [NUM_STATES-1:0] state_o,
  output logic                  out_of_area
);
  logic [NUM_STATES-1:0] z_q;
  logic [NUM_STATES-1:0] z_d;
  logic [NUM_STATES-1:0] table_nxt;
  logic [NUM_RULES-1:0]  hit;

  ohm_product_plane u_prod (
    .x_i   (x_i),
    .z_i   (z_q),
    .hit_o (hit)
  );

  ohm_or_plane u_or (
    .hit_i (hit),
    .nxt_o (table_nxt),
    .y_o   (y_o)
  );

  ohm_area_check u_area (
    .z_i       (z_q),
    .hit_i     (hit),
    .outside_o (out_of_area)
  );

  // Next-state selection: load wins over the table.
  always_comb begin
    z_d = table_nxt;
    if (ld_en) z_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= RESET_CODE;
    end else begin
      z_q <= z_d;
    end
  end

  assign state_o = z_q;
endmodule

// File: rtl/ohm_ctrl_chk.sv
module ohm_ctrl_chk
  import ohm_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_IN-1:0]     x_i,
  input logic                  ld_en,
  input logic [NUM_STATES-1:0] ld_val,
  input logic [NUM_OUT-1:0]    y_o,
  input logic [NUM_STATES-1:0] state_o,
  input logic                  out_of_area
);
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> state_o == $past(ld_val));

  p_onehot_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && $countones(state_o) == 1) |=> $countones(state_o) == 1);

  p_flag_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_area == ($countones(state_o) != 1));

  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == '0) |-> (y_o == '0));

  p_zero_stuck_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && state_o == '0) |=> state_o == '0);

  p_s2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && state_o == 4'b0010 && !x_i[2]) |=> state_o == 4'b0010);
endmodule

bind ohm_ctrl ohm_ctrl_chk u_chk (.*);

// File: tb/sim_ohm_ctrl.sv
`timescale 1ns/1ps
module sim_ohm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] x_i = '0;
  logic       ld_en = 1'b0;
  logic [3:0] ld_val = '0;
  logic [2:0] y_o;
  logic [3:0] state_o;
  logic       out_of_area;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ohm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .x_i(x_i), .ld_en(ld_en), .ld_val(ld_val),
    .y_o(y_o), .state_o(state_o), .out_of_area(out_of_area)
  );

  // Table model for one source state s (0..3). x[k-1]=xk, y[k-1]=yk.
  task automatic row(input int s, input logic [2:0] x,
                     output int d, output logic [2:0] y);
    logic x1, x2, x3;
    x1 = x[0]; x2 = x[1]; x3 = x[2];
    d = s; y = 3'b000;
    case (s)
      0: if (x1 && x2) begin d = 1; y = 3'b101; end
         else          begin d = 0; y = 3'b100; end  // R2
      1: if (x3) begin d = 2; y = 3'b111; end
         else    begin d = 1; y = 3'b110; end        // R3
      2: if (!x1)    begin d = 3; y = 3'b011; end
         else if (x2) begin d = 3; y = 3'b110; end
         else         begin d = 2; y = 3'b010; end   // R4
      default: if (x3) begin d = 0; y = 3'b111; end
               else    begin d = 3; y = 3'b110; end  // R5
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic [3:0] v, input logic [2:0] x);
    @(negedge clk);
    ld_en = l; ld_val = v; x_i = x;
    #1;
  endtask

  task automatic edge_settle();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [2:0] walk [12];
    logic [3:0] cur;
    int d;
    logic [2:0] yy;

    walk = '{3'b000, 3'b011, 3'b000, 3'b100, 3'b001, 3'b000,
             3'b000, 3'b100, 3'b011, 3'b100, 3'b011, 3'b101};

    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    chk(state_o == 4'b0001, "R1", "state during reset", state_o, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(state_o == 4'b0001, "R1", "state after release", state_o, 1);
    chk(out_of_area == 1'b0, "R1", "flag after release", out_of_area, 0);

    // Walk the table from reset with control inputs only (R2..R5).
    cur = 4'b0001;
    foreach (walk[i]) begin
      int s;
      s = 0;
      for (int b = 0; b < 4; b++) if (cur[b]) s = b;
      drive(1'b0, 4'b0000, walk[i]);
      row(s, walk[i], d, yy);
      chk(y_o == yy, $sformatf("R%0d", s + 2), "walk output", y_o, yy);
      chk(out_of_area == 1'b0, "R8", "walk flag", out_of_area, 0);
      edge_settle();
      cur = 4'b0001 << d;
      chk(state_o == cur, $sformatf("R%0d", s + 2), "walk next", state_o, cur);
    end

    // Load beats a table transition (R9): state 1 with x1=x2=1 would go to 2.
    drive(1'b1, 4'b0001, 3'b000);
    edge_settle();
    drive(1'b1, 4'b1000, 3'b011);
    edge_settle();
    chk(state_o == 4'b1000, "R9", "load priority", state_o, 8);

    // Sweep every register code against every input pattern.
    for (int code = 0; code < 16; code++) begin
      for (int xv = 0; xv < 8; xv++) begin
        logic [3:0] en;
        logic [2:0] ey;
        logic       ef;
        string      tag;
        int         nset;
        drive(1'b1, 4'(code), 3'(xv));
        edge_settle();
        chk(state_o == 4'(code), "R9", "loaded code", state_o, code);
        drive(1'b0, 4'b0000, 3'(xv));
        en = '0; ey = '0; nset = 0;
        for (int s = 0; s < 4; s++) begin
          if (code[s]) begin
            row(s, 3'(xv), d, yy);
            en[d] = 1'b1;
            ey = ey | yy;
            nset++;
          end
        end
        ef = (nset != 1);
        if (nset == 0) tag = "R7";
        else if (nset > 1) tag = "R6";
        else begin
          tag = "R2";
          for (int s = 0; s < 4; s++) if (code[s]) tag = $sformatf("R%0d", s + 2);
        end
        chk(y_o == ey, tag, $sformatf("sweep output code %0h x %0h", code, xv), y_o, ey);
        chk(out_of_area == ef, "R8", $sformatf("sweep flag code %0h x %0h", code, xv),
            out_of_area, ef);
        edge_settle();
        chk(state_o == en, tag, $sformatf("sweep next code %0h x %0h", code, xv),
            state_o, en);
        if (nset == 1)
          chk($countones(state_o) == 1, "R10", "one-hot kept", state_o, en);
      end
    end

    summary();
  end
endmodule